// File: doc/BRIEF.md
# SPI Data Register Buffer

This block holds the CPU-visible data register of an SPI shifter and decides what happens to each CPU write. The write can start a transfer at once, be held back for later, or be refused. The serial engine sits outside the block. The buffer gives the engine a byte together with a one-cycle load pulse. It takes back a done pulse and the received byte when the transfer ends. Between those two events a transfer counts as in progress.

A mode input chooses between two behaviours, and a single status flag changes meaning with it. In normal mode a write during a transfer is a collision: the byte is thrown away and the flag latches as an error. The flag clears only after the CPU reads the status and then touches the data register. In enhanced mode one extra byte may wait in a holding register while the current byte shifts. The flag then reads as "write buffer full". It drops when the waiting byte moves to the shifter at the start of the next transfer. The data register, the shift byte and the holding byte have no reset, so their contents survive a reset.

The transfer controller has three states. XS_IDLE moves to XS_SHIFT on any write. XS_SHIFT moves to XS_SHIFT_Q on an enhanced-mode write. On done, XS_SHIFT moves to XS_IDLE, or stays in XS_SHIFT when an enhanced-mode write arrives in the same cycle. XS_SHIFT_Q returns to XS_SHIFT on done. The collision tracker also has three states. WC_CLEAR moves to WC_SET on a collision. WC_SET moves to WC_ARMED on a status read. WC_ARMED moves to WC_CLEAR on a data-register read or write, or back to WC_SET if that write itself collides. Enhanced mode holds the collision tracker in WC_CLEAR.

Top module: `spi_data_buffer`

## Requirements
- R1: A write while no transfer is in progress is accepted in either mode. On the next cycle tx_load is 1 for exactly one cycle, and tx_byte and rd_data both equal the written byte.
- R2: In normal mode (enh_mode=0), a write while a transfer is in progress sets flag to 1 on the next cycle. The byte is discarded: tx_byte and rd_data keep their values and no tx_load is issued.
- R3: In normal mode, once set, flag stays 1 until a status read (stat_rd) is followed later by a data-register read or write. A data access without an earlier status read leaves it at 1, and so does a status read on its own.
- R4: In enhanced mode (enh_mode=1), the first write during a transfer is queued. On the next cycle flag is 1 (buffer full), tx_byte is unchanged, no tx_load is issued, and rd_data shows the queued byte.
- R5: In enhanced mode, when eng_done ends a transfer with a byte queued, the next cycle has tx_load=1 and tx_byte equal to the queued byte, and flag is back at 0 in that same cycle.
- R6: In enhanced mode, a write while the buffer is full is ignored. The flag stays 1 and the byte that is launched next is the one queued first.
- R7: The cycle after eng_done (with no write in the same cycle), rd_data equals eng_rx as sampled with eng_done.
- R8: During and after reset, flag is 0 and tx_load is 0, while rd_data keeps the value it held before reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| enh_mode | input | 1 | 0 = normal (collision) mode, 1 = enhanced (double-buffered) mode |
| wr_en | input | 1 | CPU write strobe for the data register |
| wr_data | input | DATA_W | CPU write byte |
| rd_en | input | 1 | CPU read strobe for the data register |
| stat_rd | input | 1 | CPU read strobe for the status register holding flag |
| rd_data | output | DATA_W | Data register contents as seen by the CPU |
| eng_done | input | 1 | One-cycle pulse from the shift engine ending a transfer |
| eng_rx | input | DATA_W | Byte received by the engine, valid with eng_done |
| tx_load | output | 1 | One-cycle pulse telling the engine to start shifting tx_byte |
| tx_byte | output | DATA_W | Byte handed to the shift engine |
| flag | output | 1 | Collision flag (normal mode) or write-buffer-full (enhanced mode) |

## Verification
The assertions assume that enh_mode changes only while no transfer is in progress and nothing is queued. They also assume that eng_done comes only after a tx_load, and never in the cycle that directly follows it. The bench's engine model answers each load with done after a fixed latency of several cycles. Mode changes in the bench happen only after the last done has been consumed. CPU strobes are never placed in a done cycle, except in the paths where the requirements define the result.

// File: rtl/spi_dbuf_pkg.sv
package spi_dbuf_pkg;

    typedef enum logic [1:0] {
        XS_IDLE   = 2'd0,
        XS_SHIFT  = 2'd1,
        XS_SHIFT_Q = 2'd2
    } xfer_state_e;

    typedef enum logic [1:0] {
        WC_CLEAR = 2'd0,
        WC_SET   = 2'd1,
        WC_ARMED = 2'd2
    } wcol_state_e;

endpackage

// File: rtl/spi_dbuf_xfer_fsm.sv
module spi_dbuf_xfer_fsm
    import spi_dbuf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enh_mode,
    input  logic wr_en,
    input  logic eng_done,
    output logic active,
    output logic queued,
    output logic load_direct,
    output logic load_queue,
    output logic queue_wr,
    output logic collide,
    output logic cap_rx,
    output logic tx_load
);

    xfer_state_e state_q, state_d;
    logic        tx_load_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= XS_IDLE;
            tx_load_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            tx_load_q <= load_direct | load_queue;
        end
    end

    // next state and control outputs
    always_comb begin
        state_d     = state_q;
        load_direct = 1'b0;
        load_queue  = 1'b0;
        queue_wr    = 1'b0;
        collide     = 1'b0;
        cap_rx      = 1'b0;
        unique case (state_q)
            XS_IDLE: begin
                if (wr_en) begin
                    load_direct = 1'b1;
                    state_d     = XS_SHIFT;
                end
            end
            XS_SHIFT: begin
                cap_rx = eng_done;
                if (enh_mode) begin
                    if (wr_en && eng_done) begin
                        load_direct = 1'b1;
                        state_d     = XS_SHIFT;
                    end else if (wr_en) begin
                        queue_wr = 1'b1;
                        state_d  = XS_SHIFT_Q;
                    end else if (eng_done) begin
                        state_d = XS_IDLE;
                    end
                end else begin
                    collide = wr_en;
                    if (eng_done) begin
                        state_d = XS_IDLE;
                    end
                end
            end
            XS_SHIFT_Q: begin
                cap_rx = eng_done;
                if (eng_done) begin
                    load_queue = 1'b1;
                    state_d    = XS_SHIFT;
                end
            end
            default: begin
                state_d = XS_IDLE;
            end
        endcase
    end

    assign active  = (state_q != XS_IDLE);
    assign queued  = (state_q == XS_SHIFT_Q);
    assign tx_load = tx_load_q;

endmodule

// File: rtl/spi_dbuf_wcol_fsm.sv
module spi_dbuf_wcol_fsm
    import spi_dbuf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enh_mode,
    input  logic collide,
    input  logic stat_rd,
    input  logic rd_en,
    input  logic wr_en,
    output logic wcol
);

    wcol_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WC_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WC_CLEAR: begin
                if (collide) state_d = WC_SET;
            end
            WC_SET: begin
                if (stat_rd) state_d = WC_ARMED;
            end
            WC_ARMED: begin
                if (collide)               state_d = WC_SET;
                else if (rd_en || wr_en)   state_d = WC_CLEAR;
            end
            default: begin
                state_d = WC_CLEAR;
            end
        endcase
        if (enh_mode) state_d = WC_CLEAR;
    end

    // output
    always_comb begin
        wcol = (state_q != WC_CLEAR);
    end

endmodule

// File: rtl/spi_dbuf_regs.sv
module spi_dbuf_regs #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] eng_rx,
    input  logic              load_direct,
    input  logic              load_queue,
    input  logic              queue_wr,
    input  logic              cap_rx,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] tx_byte,
    output logic [DATA_W-1:0] hold
);

    logic [DATA_W-1:0] dreg_q;
    logic [DATA_W-1:0] shift_q;
    logic [DATA_W-1:0] hold_q;

    // CPU-visible register: no reset, a CPU write wins over a received byte
    always_ff @(posedge clk) begin
        if (load_direct || queue_wr) begin
            dreg_q <= wr_data;
        end else if (cap_rx) begin
            dreg_q <= eng_rx;
        end
    end

    // byte offered to the engine
    always_ff @(posedge clk) begin
        if (load_direct) begin
            shift_q <= wr_data;
        end else if (load_queue) begin
            shift_q <= hold_q;
        end
    end

    // enhanced-mode holding register
    always_ff @(posedge clk) begin
        if (queue_wr) begin
            hold_q <= wr_data;
        end
    end

    assign rd_data = dreg_q;
    assign tx_byte = shift_q;
    assign hold    = hold_q;

endmodule

// File: rtl/spi_data_buffer.sv
module spi_data_buffer #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enh_mode,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic              stat_rd,
    output logic [DATA_W-1:0] rd_data,
    input  logic              eng_done,
    input  logic [DATA_W-1:0] eng_rx,
    output logic              tx_load,
    output logic [DATA_W-1:0] tx_byte,
    output logic              flag
);

    logic              xfer_active;
    logic              buf_full;
    logic              load_direct;
    logic              load_queue;
    logic              queue_wr;
    logic              collide;
    logic              cap_rx;
    logic              wcol;
    logic [DATA_W-1:0] hold_q;

    spi_dbuf_xfer_fsm xfer_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .enh_mode    (enh_mode),
        .wr_en       (wr_en),
        .eng_done    (eng_done),
        .active      (xfer_active),
        .queued      (buf_full),
        .load_direct (load_direct),
        .load_queue  (load_queue),
        .queue_wr    (queue_wr),
        .collide     (collide),
        .cap_rx      (cap_rx),
        .tx_load     (tx_load)
    );

    spi_dbuf_wcol_fsm wcol_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .enh_mode (enh_mode),
        .collide  (collide),
        .stat_rd  (stat_rd),
        .rd_en    (rd_en),
        .wr_en    (wr_en),
        .wcol     (wcol)
    );

    spi_dbuf_regs #(.DATA_W(DATA_W)) regs_i (
        .clk         (clk),
        .wr_data     (wr_data),
        .eng_rx      (eng_rx),
        .load_direct (load_direct),
        .load_queue  (load_queue),
        .queue_wr    (queue_wr),
        .cap_rx      (cap_rx),
        .rd_data     (rd_data),
        .tx_byte     (tx_byte),
        .hold        (hold_q)
    );

    // one flag, two meanings selected by mode
    assign flag = enh_mode ? buf_full : wcol;

endmodule

// File: rtl/spi_dbuf_chk.sv
module spi_dbuf_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enh_mode,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic              rd_en,
    input logic [DATA_W-1:0] rd_data,
    input logic              eng_done,
    input logic [DATA_W-1:0] eng_rx,
    input logic              tx_load,
    input logic [DATA_W-1:0] tx_byte,
    input logic              flag,
    input logic              xfer_active,
    input logic              buf_full,
    input logic [DATA_W-1:0] hold_q
);

    // R1
    idle_write_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer_active && wr_en) |=> (tx_load && tx_byte == $past(wr_data)));

    // R2
    collide_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!enh_mode && xfer_active && wr_en) |=> (flag && !tx_load && $stable(tx_byte)));

    // R3
    wcol_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!enh_mode && flag && !rd_en && !wr_en) |=> flag);

    // R4
    queue_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enh_mode && xfer_active && !buf_full && wr_en && !eng_done) |=> (flag && !tx_load));

    // R5
    dequeue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enh_mode && buf_full && eng_done) |=> (tx_load && !flag && tx_byte == $past(hold_q)));

    // R6
    full_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enh_mode && buf_full && wr_en && !eng_done) |=> (flag && $stable(hold_q) && $stable(tx_byte)));

    // R7
    rx_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_active && eng_done && !wr_en) |=> (rd_data == $past(eng_rx)));

    // R8
    always @(negedge clk) begin
        if (!rst_n) begin
            reset_quiet_chk: assert (!tx_load && !flag);
        end
    end

endmodule

bind spi_data_buffer spi_dbuf_chk #(.DATA_W(DATA_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .enh_mode    (enh_mode),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .rd_en       (rd_en),
    .rd_data     (rd_data),
    .eng_done    (eng_done),
    .eng_rx      (eng_rx),
    .tx_load     (tx_load),
    .tx_byte     (tx_byte),
    .flag        (flag),
    .xfer_active (xfer_active),
    .buf_full    (buf_full),
    .hold_q      (hold_q)
);

// File: tb/spi_data_buffer_tb.sv
module spi_data_buffer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 8;
    localparam int LAT        = 5;
    localparam int SWEEP      = 16;
    localparam int WD_CYCLES  = 50000;
    localparam logic [W-1:0] RX_MASK = 8'hA5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         enh_mode = 1'b0;
    logic         wr_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         rd_en = 1'b0;
    logic         stat_rd = 1'b0;
    logic [W-1:0] rd_data;
    logic         eng_done;
    logic [W-1:0] eng_rx;
    logic         tx_load;
    logic [W-1:0] tx_byte;
    logic         flag;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_data_buffer #(.DATA_W(W)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .enh_mode (enh_mode),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_en    (rd_en),
        .stat_rd  (stat_rd),
        .rd_data  (rd_data),
        .eng_done (eng_done),
        .eng_rx   (eng_rx),
        .tx_load  (tx_load),
        .tx_byte  (tx_byte),
        .flag     (flag)
    );

    // shift engine model: done LAT cycles after a load, rx = tx ^ mask
    logic         eng_busy;
    int           eng_cnt;
    logic [W-1:0] eng_tx;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_busy <= 1'b0;
            eng_cnt  <= 0;
            eng_done <= 1'b0;
            eng_rx   <= '0;
            eng_tx   <= '0;
        end else begin
            eng_done <= 1'b0;
            if (tx_load) begin
                eng_busy <= 1'b1;
                eng_cnt  <= LAT;
                eng_tx   <= tx_byte;
            end else if (eng_busy) begin
                if (eng_cnt == 1) begin
                    eng_busy <= 1'b0;
                    eng_done <= 1'b1;
                    eng_rx   <= eng_tx ^ RX_MASK;
                end
                eng_cnt <= eng_cnt - 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    task automatic do_write(input logic [W-1:0] v);
        wr_en = 1'b1; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read();
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic do_stat();
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
    endtask

    task automatic wait_done();
        while (!eng_done) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        summary();
    end

    initial begin
        logic [W-1:0] a, b, c, keep;
        repeat (3) @(negedge clk);
        // R8: reset state
        check(!flag && !tx_load, "R8 reset outputs", {flag, tx_load}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1, R7: sweep in both modes
        for (int m = 0; m < 2; m++) begin
            enh_mode = m[0];
            @(negedge clk);
            for (int i = 0; i < SWEEP; i++) begin
                a = W'((i * 37 + 11 + m * 101) % 256);
                do_write(a);
                check(tx_load == 1'b1, "R1 load pulse", tx_load, 1);
                check(tx_byte == a, "R1 tx_byte", tx_byte, a);
                check(rd_data == a, "R1 rd_data", rd_data, a);
                @(negedge clk);
                check(tx_load == 1'b0, "R1 single pulse", tx_load, 0);
                wait_done();
                check(rd_data == (a ^ RX_MASK), "R7 rx capture", rd_data, a ^ RX_MASK);
                check(flag == 1'b0, "R1 flag clear", flag, 0);
            end
        end

        // R2, R3: normal-mode collisions
        enh_mode = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            a = W'(8'h30 + i);
            b = W'(8'hC0 + i * 3);
            do_write(a);
            do_write(b);
            check(flag == 1'b1, "R2 collision flag", flag, 1);
            check(tx_byte == a, "R2 tx_byte kept", tx_byte, a);
            check(rd_data == a, "R2 rd_data kept", rd_data, a);
            check(tx_load == 1'b0, "R2 no load", tx_load, 0);
            do_read();
            check(flag == 1'b1, "R3 access without status read", flag, 1);
            wait_done();
            check(rd_data == (a ^ RX_MASK), "R2 shifted byte intact", rd_data, a ^ RX_MASK);
            check(flag == 1'b1, "R3 flag holds after done", flag, 1);
            do_stat();
            repeat (2) @(negedge clk);
            check(flag == 1'b1, "R3 status read alone", flag, 1);
            if (i[0]) begin
                do_read();
                check(flag == 1'b0, "R3 clear by read", flag, 0);
            end else begin
                c = W'(8'h55 + i);
                do_write(c);
                check(flag == 1'b0, "R3 clear by write", flag, 0);
                check(tx_load == 1'b1 && tx_byte == c, "R3 clearing write launches", tx_byte, c);
                wait_done();
            end
        end

        // R4, R5, R6: enhanced-mode queueing
        enh_mode = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            a = W'(8'h10 + i * 7);
            b = W'(8'h80 + i * 5);
            c = W'(8'hE0 + i);
            do_write(a);
            do_write(b);
            check(flag == 1'b1, "R4 buffer full", flag, 1);
            check(tx_byte == a, "R4 tx_byte kept", tx_byte, a);
            check(tx_load == 1'b0, "R4 no load", tx_load, 0);
            check(rd_data == b, "R4 rd_data queued", rd_data, b);
            do_write(c);
            check(flag == 1'b1, "R6 still full", flag, 1);
            wait_done();
            check(tx_load == 1'b1, "R5 queued launch", tx_load, 1);
            check(tx_byte == b, "R6 first queued byte launched", tx_byte, b);
            check(flag == 1'b0, "R5 flag cleared", flag, 0);
            check(rd_data == (a ^ RX_MASK), "R7 rx of first", rd_data, a ^ RX_MASK);
            wait_done();
            check(rd_data == (b ^ RX_MASK), "R6 ignored byte never sent", rd_data, b ^ RX_MASK);
            repeat (LAT + 2) @(negedge clk);
            check(tx_load == 1'b0 && flag == 1'b0, "R6 no third transfer", {tx_load, flag}, 0);
        end

        // R8: reset leaves data register intact
        keep = rd_data;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(!flag && !tx_load, "R8 outputs in reset", {flag, tx_load}, 0);
        check(rd_data == keep, "R8 data kept in reset", rd_data, keep);
        rst_n = 1'b1;
        @(negedge clk);
        check(rd_data == keep, "R8 data kept after reset", rd_data, keep);

        summary();
    end

endmodule